// File: doc/BRIEF.md
# Stoppable Real-Time Clock Timebase

This block keeps time of day (hours, minutes, seconds) from a 32.768 kHz timing enable. A 15-stage binary prescaler divides the enable down. The time counters advance by one second each time the most significant prescaler stage goes from 0 to 1. All logic runs on a single system clock. The 32.768 kHz rate arrives as a one-cycle enable pulse in that clock domain.

A stop input halts timekeeping. While stop is high, the time fields hold their value, and prescaler stages 2 and up are forced to zero. The two lowest stages keep dividing. Software raises stop, writes a new time through the load port, and drops stop. The first one-second step then lands about half a second after release, and every later step follows at exact one-second spacing. A load offered while the clock is running is discarded.

Top module: `rtc_timebase`

## Requirements
- R1: A synchronous reset sets hours, minutes and seconds to 00:00:00 and clears every prescaler stage.
- R2: While running, the seconds value steps once every 32768 tick enables. The first step after reset comes 16384 tick enables after reset.
- R3: While stop is high, tick enables do not change the time outputs.
- R4: A load offered while stop is high replaces all three time fields on the next clock. The new value is held unchanged for as long as stop stays high.
- R5: A load offered while stop is low has no effect on the time outputs.
- R6: While stop is high, prescaler stages 2 to 14 stay at zero, and stages 0 and 1 keep counting tick enables modulo 4. Let L be the number of tick enables since reset, modulo 4, at the moment stop drops. The first time step after release then comes 16384 − L tick enables after release.
- R7: Only a 0-to-1 transition of prescaler stage 14 steps the time. Its 1-to-0 transition, 16384 tick enables after a step, leaves the time unchanged.
- R8: Seconds and minutes wrap from 59 to 00. Each wrap carries one step into the next field.
- R9: Hours use 24-hour form and wrap from 23 to 00.
- R10: Each time field is two-digit BCD. Bits 7:4 hold the tens digit and bits 3:0 hold the units digit, so units go from 9 to 0 with a carry into the tens.
- R11: Clock cycles without a tick enable advance neither the prescaler nor the time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| stop | input | 1 | High freezes the time and clears the upper prescaler stages |
| load_en | input | 1 | Load strobe, honoured only while stop is high |
| load_hours | input | 8 | BCD hours to load (00–23) |
| load_mins | input | 8 | BCD minutes to load (00–59) |
| load_secs | input | 8 | BCD seconds to load (00–59) |
| hours | output | 8 | Current BCD hours |
| mins | output | 8 | Current BCD minutes |
| secs | output | 8 | Current BCD seconds |

## Verification
The assertions are checked on every clock cycle. They cover the following:
- The time holds while stopped with no load.
- The time changes only because of a stopped load or a rise of the top prescaler stage.
- Each such rise moves the seconds.
- The upper stages stay cleared during stop, and the two low stages still count.
- The BCD digits stay in range.

Only the bench scenarios can show the absolute timing:
- the step 16384 enables after reset
- the release-phase offset that depends on the low-stage residue
- the exact one-second spacing
- the carry chain through 23:59:59 and 09:59:59

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef logic [7:0] bcd_t;

   localparam int unsigned FIELD_CNT = 3;
   localparam int unsigned FLD_SEC   = 0;
   localparam int unsigned FLD_MIN   = 1;
   localparam int unsigned FLD_HOUR  = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned STAGES   = 15,
   parameter int unsigned KEEP_LOW = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              stop,
   output logic [STAGES-1:0] count
);
   localparam logic [STAGES-1:0] ONE      = STAGES'(1);
   localparam logic [STAGES-1:0] LOW_MASK = STAGES'((64'd1 << KEEP_LOW) - 64'd1);

   if (STAGES < 2 || STAGES > 31) begin : g_bad_stages
      $error("rtc_prescaler: STAGES must lie in 2..31");
   end
   if (KEEP_LOW >= STAGES) begin : g_bad_keep
      $error("rtc_prescaler: KEEP_LOW must be below STAGES");
   end

   logic [STAGES-1:0] advanced;
   logic [STAGES-1:0] count_d;

   always_comb begin
      advanced = tick ? (count + ONE) : count;
      count_d  = stop ? (advanced & LOW_MASK) : advanced;
   end

   always_ff @(posedge clk) begin
      if (rst) count <= '0;
      else     count <= count_d;
   end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_pkg::*;
#(
   parameter int unsigned LIMIT = 59
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   input  logic load,
   input  bcd_t load_val,
   output bcd_t value,
   output logic at_limit
);
   localparam bcd_t LIMIT_BCD = bcd_t'(((LIMIT / 10) * 16) + (LIMIT % 10));

   if (LIMIT < 1 || LIMIT > 99) begin : g_bad_limit
      $error("rtc_bcd_field: LIMIT must lie in 1..99");
   end

   bcd_t stepped;
   bcd_t value_d;

   assign at_limit = (value == LIMIT_BCD);

   always_comb begin
      if (at_limit)
         stepped = '0;
      else if (value[3:0] == 4'd9)
         stepped = {value[7:4] + 4'd1, 4'd0};
      else
         stepped = {value[7:4], value[3:0] + 4'd1};

      if (load)      value_d = load_val;
      else if (step) value_d = stepped;
      else           value_d = value;
   end

   always_ff @(posedge clk) begin
      if (rst) value <= '0;
      else     value <= value_d;
   end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
   import rtc_pkg::*;
#(
   parameter int unsigned PRE_STAGES   = 15,
   parameter int unsigned PRE_KEEP_LOW = 2,
   parameter int unsigned MINSEC_LIMIT = 59,
   parameter int unsigned HOUR_LIMIT   = 23
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick_32k,
   input  logic       stop,
   input  logic       load_en,
   input  logic [7:0] load_hours,
   input  logic [7:0] load_mins,
   input  logic [7:0] load_secs,
   output logic [7:0] hours,
   output logic [7:0] mins,
   output logic [7:0] secs
);
   localparam int unsigned MSB = PRE_STAGES - 1;
   localparam logic [PRE_STAGES-1:0] RISE_PRE = {1'b0, {MSB{1'b1}}};

   if (PRE_KEEP_LOW >= MSB) begin : g_bad_keep
      $error("rtc_timebase: PRE_KEEP_LOW must leave the top stage clearable");
   end

   logic [PRE_STAGES-1:0] presc_q;
   logic                  sec_step;
   logic                  do_load;
   bcd_t                  load_vals [FIELD_CNT];
   bcd_t                  field_q   [FIELD_CNT];
   logic [FIELD_CNT-1:0]  field_wrap;
   logic [FIELD_CNT-1:0]  field_step;
   logic                  unused_top_wrap;

   rtc_prescaler #(
      .STAGES   (PRE_STAGES),
      .KEEP_LOW (PRE_KEEP_LOW)
   ) presc_i (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick_32k),
      .stop  (stop),
      .count (presc_q)
   );

   // the top stage rises on the edge where the lower stages roll over
   assign sec_step = tick_32k && !stop && (presc_q == RISE_PRE);
   assign do_load  = load_en && stop;

   assign load_vals[FLD_SEC]  = load_secs;
   assign load_vals[FLD_MIN]  = load_mins;
   assign load_vals[FLD_HOUR] = load_hours;

   for (genvar g = 0; g < FIELD_CNT; g++) begin : g_field
      localparam int unsigned LIM = (g == FLD_HOUR) ? HOUR_LIMIT : MINSEC_LIMIT;

      if (g == 0) begin : g_first
         assign field_step[g] = sec_step;
      end else begin : g_chain
         assign field_step[g] = field_step[g-1] && field_wrap[g-1];
      end

      rtc_bcd_field #(
         .LIMIT (LIM)
      ) fld_i (
         .clk      (clk),
         .rst      (rst),
         .step     (field_step[g]),
         .load     (do_load),
         .load_val (load_vals[g]),
         .value    (field_q[g]),
         .at_limit (field_wrap[g])
      );
   end

   assign unused_top_wrap = field_wrap[FIELD_CNT-1];

   assign secs  = field_q[FLD_SEC];
   assign mins  = field_q[FLD_MIN];
   assign hours = field_q[FLD_HOUR];
endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk #(
   parameter int unsigned STAGES   = 15,
   parameter int unsigned KEEP_LOW = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              tick_32k,
   input logic              stop,
   input logic              load_en,
   input logic [7:0]        hours,
   input logic [7:0]        mins,
   input logic [7:0]        secs,
   input logic [STAGES-1:0] pre_cnt
);
   localparam int unsigned MSB = STAGES - 1;

   // R3: stopped and not loading, the time holds
   a_r3_frozen_when_stopped: assert property (@(posedge clk) disable iff (rst)
      (stop && !load_en) |=> $stable({hours, mins, secs}));

   // R5: time moves only through a stopped load or a rise of the top stage
   a_r5_change_has_cause: assert property (@(posedge clk) disable iff (rst)
      !$stable({hours, mins, secs}) |-> ($past(stop && load_en) || $rose(pre_cnt[MSB])));

   // R7: every rise of the top stage moves the seconds
   a_r7_rise_steps_secs: assert property (@(posedge clk) disable iff (rst)
      $rose(pre_cnt[MSB]) |-> !$stable(secs));

   // R6: upper stages stay clear while stopped
   a_r6_upper_clear: assert property (@(posedge clk) disable iff (rst)
      $past(stop) |-> ((pre_cnt >> KEEP_LOW) == '0));

   if (KEEP_LOW > 0) begin : g_low_run
      // R6: low stages keep counting ticks during stop
      a_r6_low_stages_run: assert property (@(posedge clk) disable iff (rst)
         (stop && tick_32k) |=> (pre_cnt[KEEP_LOW-1:0] ==
            KEEP_LOW'($past(pre_cnt[KEEP_LOW-1:0]) + 1'b1)));
   end

   // R10: BCD digits stay legal
   a_r10_bcd_digits: assert property (@(posedge clk) disable iff (rst)
      (secs[3:0] <= 4'd9) && (mins[3:0] <= 4'd9) && (hours[3:0] <= 4'd9)
      && (secs <= 8'h59) && (mins <= 8'h59) && (hours <= 8'h23));
endmodule

bind rtc_timebase rtc_timebase_chk #(
   .STAGES   (PRE_STAGES),
   .KEEP_LOW (PRE_KEEP_LOW)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .tick_32k (tick_32k),
   .stop     (stop),
   .load_en  (load_en),
   .hours    (hours),
   .mins     (mins),
   .secs     (secs),
   .pre_cnt  (presc_q)
);

// File: tb/rtc_timebase_tb_top.sv
`timescale 1ns/1ps
module rtc_timebase_tb_top;
   typedef struct {
      logic [7:0] h;
      logic [7:0] m;
      logic [7:0] s;
      string      req;
   } exp_item_t;

   logic       clk = 1'b0;
   logic       rst;
   logic       tick_32k;
   logic       stop;
   logic       load_en;
   logic [7:0] load_hours;
   logic [7:0] load_mins;
   logic [7:0] load_secs;
   logic [7:0] hours;
   logic [7:0] mins;
   logic [7:0] secs;

   int        vectors = 0;
   int        miscompares = 0;
   int        tot = 0;
   bit        done = 1'b0;
   exp_item_t exp_q[$];
   event      chk_ev;

   always #4 clk = ~clk;

   rtc_timebase dut_i (
      .clk        (clk),
      .rst        (rst),
      .tick_32k   (tick_32k),
      .stop       (stop),
      .load_en    (load_en),
      .load_hours (load_hours),
      .load_mins  (load_mins),
      .load_secs  (load_secs),
      .hours      (hours),
      .mins       (mins),
      .secs       (secs)
   );

   // monitor: drains the scoreboard queue whenever the driver posts items
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            vectors++;
            if (hours !== it.h || mins !== it.m || secs !== it.s) begin
               miscompares++;
               $display("FAIL %s: got %h:%h:%h expected %h:%h:%h",
                        it.req, hours, mins, secs, it.h, it.m, it.s);
            end
         end
      end
   end

   task automatic expect_time(input logic [7:0] h, input logic [7:0] m,
                              input logic [7:0] s, input string req);
      exp_item_t it;
      it.h = h; it.m = m; it.s = s; it.req = req;
      exp_q.push_back(it);
      -> chk_ev;
      #0;
   endtask

   task automatic run_ticks(input int n);
      repeat (n) begin
         tick_32k = 1'b1;
         @(negedge clk);
         tot++;
      end
      tick_32k = 1'b0;
   endtask

   task automatic idle(input int n);
      tick_32k = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic offer_load(input logic [7:0] h, input logic [7:0] m,
                             input logic [7:0] s);
      load_hours = h; load_mins = m; load_secs = s;
      load_en = 1'b1;
      @(negedge clk);
      load_en = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got no completion expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int low;
      rst = 1'b1; tick_32k = 1'b0; stop = 1'b0; load_en = 1'b0;
      load_hours = '0; load_mins = '0; load_secs = '0;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      tot = 0;
      expect_time(8'h00, 8'h00, 8'h00, "R1 reset state");

      // gaps without tick must not count (R11); first step at 16384 (R1, R2)
      run_ticks(8000);
      idle(100);
      run_ticks(8383);
      expect_time(8'h00, 8'h00, 8'h00, "R11 gaps do not count");
      run_ticks(1);
      expect_time(8'h00, 8'h00, 8'h01, "R2 first step after reset");

      // falling top stage does nothing (R7); next step exactly 32768 later (R2)
      run_ticks(16384);
      expect_time(8'h00, 8'h00, 8'h01, "R7 falling edge no step");
      run_ticks(16383);
      expect_time(8'h00, 8'h00, 8'h01, "R2 one tick before step");
      run_ticks(1);
      expect_time(8'h00, 8'h00, 8'h02, "R2 one second spacing");

      // load while running is ignored
      offer_load(8'h12, 8'h34, 8'h56);
      idle(2);
      expect_time(8'h00, 8'h00, 8'h02, "R5 load while running");

      // stop freezes time
      stop = 1'b1;
      run_ticks(5);
      expect_time(8'h00, 8'h00, 8'h02, "R3 frozen under stop");
      offer_load(8'h23, 8'h59, 8'h59);
      expect_time(8'h23, 8'h59, 8'h59, "R4 load applied");
      run_ticks(2);
      expect_time(8'h23, 8'h59, 8'h59, "R4 load held");

      // release: first step after 16384 - L ticks
      low = tot % 4;
      stop = 1'b0;
      run_ticks(16384 - low - 1);
      expect_time(8'h23, 8'h59, 8'h59, "R6 just before first step");
      run_ticks(1);
      expect_time(8'h00, 8'h00, 8'h00, "R6 R8 R9 first step wraps day");
      run_ticks(16384);
      expect_time(8'h00, 8'h00, 8'h00, "R7 no step on fall after release");
      run_ticks(16383);
      expect_time(8'h00, 8'h00, 8'h00, "R2 before step after release");
      run_ticks(1);
      expect_time(8'h00, 8'h00, 8'h01, "R2 step after release");

      // BCD units carry in every field
      stop = 1'b1;
      run_ticks(1);
      offer_load(8'h09, 8'h59, 8'h59);
      expect_time(8'h09, 8'h59, 8'h59, "R4 second load applied");
      low = tot % 4;
      stop = 1'b0;
      run_ticks(16384 - low - 1);
      expect_time(8'h09, 8'h59, 8'h59, "R6 before step, second release");
      run_ticks(1);
      expect_time(8'h10, 8'h00, 8'h00, "R10 R8 BCD carry into hours tens");

      idle(2);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule